// File: doc/BRIEF.md
# DRAM Column Command Spacing Checker

This block sits on the command stream of one DDR3 rank and enforces the minimum spacing rules that apply to column commands (READ, WRITE), bank PRECHARGE and mode-register-set (MRS). For each command class it drives a ready signal that is high when a command of that class may legally issue this cycle. The command stream is a valid/ready interface: a command is presented with `cmd_valid` and a decoded type, and it is accepted on a clock edge only when the ready signal of its class is high. A command presented while its ready is low is refused. It starts no timer and sets a sticky violation flag with a 3-bit rule code. The flag stays set until `viol_clr`.

Every limit is the larger of a cycle floor and an absolute time rounded up to whole clocks at elaboration, using the clock-period parameter `TCK_PS`. Write-to-read and write-recovery are counted from the end of the write burst, which lies write latency plus half the burst length after the WRITE command. Read-to-precharge and write-recovery are tracked per bank. Column-to-column, write-to-read, MRS-to-MRS and MRS-to-other spacing are tracked for the whole rank. With the defaults (1250 ps clock, WL 6, BL 8) the spacings are: column-to-column 4, write-to-read 16, read-to-precharge 6, write-to-precharge 22, MRS-to-MRS 4 and MRS-to-other 12 cycles.

Top module: `dram_col_spacing_chk`

## Requirements
- R1: After an accepted READ or WRITE to any bank, the next READ or WRITE needs a spacing of at least CCD_NCK (4) cycles.
- R2: After an accepted WRITE, a READ needs a spacing of at least WL + BL/2 + max(4, ceil(7500 ps / TCK_PS)) cycles.
- R3: After an accepted READ to bank b, a PRECHARGE to bank b needs a spacing of at least max(4, ceil(7500 / TCK_PS)) cycles. PRECHARGE to other banks is unaffected.
- R4: After an accepted WRITE to bank b, a PRECHARGE to bank b needs a spacing of at least WL + BL/2 + ceil(15000 / TCK_PS) cycles. Other banks are unaffected.
- R5: After an accepted MRS, the next MRS needs a spacing of at least 4 cycles.
- R6: After an accepted MRS, every non-MRS command (READ, WRITE, PRECHARGE, other) needs a spacing of at least max(12, ceil(15000 / TCK_PS)) cycles.
- R7: A command is accepted on a rising edge when `cmd_valid` is high and the ready of its class is high. `rdy_pre` refers to the bank on `cmd_bank`. A refused command starts no spacing timer.
- R8: A refused command sets `viol_flag` on the same edge, and `viol_code` names the blocking rule: 1 MRS-to-other, 2 MRS-to-MRS, 3 column-to-column, 4 write-to-read, 5 read-to-precharge, 6 write-recovery. When several rules block, the lowest code is reported.
- R9: `viol_flag` and `viol_code` keep the first violation until `viol_clr` is high on an edge. A violation on the same edge as the clear is recorded after the clear.
- R10: After reset, all ready outputs are high and `viol_flag` and `viol_code` are 0.
- R11: `cmd_type` encoding: 0 other, 1 READ, 2 WRITE, 3 PRECHARGE, 4 MRS. Values 5 to 7 are treated as other. The other class is constrained only by R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_type | input | 3 | Decoded command class (R11) |
| cmd_bank | input | $clog2(NBANK) | Bank addressed by the command |
| viol_clr | input | 1 | Clears the sticky violation flag and code |
| rdy_rd | output | 1 | READ may issue this cycle |
| rdy_wr | output | 1 | WRITE may issue this cycle |
| rdy_pre | output | 1 | PRECHARGE to `cmd_bank` may issue this cycle |
| rdy_mrs | output | 1 | MRS may issue this cycle |
| rdy_oth | output | 1 | A command of the other class may issue this cycle |
| viol_flag | output | 1 | Sticky: a command was presented while blocked |
| viol_code | output | 3 | Rule that caused the first violation (R8) |

## Verification
A timer left counting or reloaded wrongly shows up as a ready signal that is one or more cycles early or late. The cycle-by-cycle gap sweep finds this at the exact gap where the ready value and the violation flag diverge from the computed limit. A bank-index or code-priority error shows up on the edge right after the refused command, as a wrong or missing `viol_code`. A refused command that wrongly starts a timer holds a ready low past the point where the legal history alone would have released it.

// File: rtl/dccs_pkg.sv
package dccs_pkg;

  localparam logic [2:0] CT_OTH = 3'd0;
  localparam logic [2:0] CT_RD  = 3'd1;
  localparam logic [2:0] CT_WR  = 3'd2;
  localparam logic [2:0] CT_PRE = 3'd3;
  localparam logic [2:0] CT_MRS = 3'd4;

  localparam logic [2:0] VC_NONE = 3'd0;
  localparam logic [2:0] VC_MOD  = 3'd1;
  localparam logic [2:0] VC_MRD  = 3'd2;
  localparam logic [2:0] VC_CCD  = 3'd3;
  localparam logic [2:0] VC_WTR  = 3'd4;
  localparam logic [2:0] VC_RTP  = 3'd5;
  localparam logic [2:0] VC_WR   = 3'd6;

  // larger of a cycle floor and a time rounded up to whole clocks
  function automatic int span_cycles(int floor_nck, int t_ps, int tck_ps);
    int c;
    c = (t_ps + tck_ps - 1) / tck_ps;
    return (c > floor_nck) ? c : floor_nck;
  endfunction

endpackage

// File: rtl/dccs_timer.sv
module dccs_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ready
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] RELOAD = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (start)          cnt <= RELOAD;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign ready = (cnt == '0);

  generate
    if (LIMIT > 1) begin : g_chk
      AST_TMR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready); // R7
    end
  endgenerate

endmodule

// File: rtl/dccs_bank_timers.sv
module dccs_bank_timers #(
  parameter int NBANK = 8,
  parameter int RTP_L = 6,
  parameter int WRR_L = 22,
  localparam int BW = (NBANK < 2) ? 1 : $clog2(NBANK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_go,
  input  logic          wr_go,
  input  logic [BW-1:0] bank,
  output logic          rtp_ok,
  output logic          wrr_ok
);
  logic [NBANK-1:0] rtp_rdy;
  logic [NBANK-1:0] wrr_rdy;

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic hit;
      assign hit = (bank == BW'(b));

      dccs_timer #(.LIMIT(RTP_L)) u_rtp (
        .clk(clk), .rst_n(rst_n), .start(rd_go && hit), .ready(rtp_rdy[b])
      );
      dccs_timer #(.LIMIT(WRR_L)) u_wrr (
        .clk(clk), .rst_n(rst_n), .start(wr_go && hit), .ready(wrr_rdy[b])
      );
    end
  endgenerate

  assign rtp_ok = rtp_rdy[bank];
  assign wrr_ok = wrr_rdy[bank];

  AST_BANK_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> (bank != $past(bank)) || !wrr_ok); // R4

endmodule

// File: rtl/dccs_viol.sv
module dccs_viol (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       hit,
  input  logic [2:0] hit_code,
  output logic       flag,
  output logic [2:0] code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      code <= 3'd0;
    end else if (hit && (!flag || clr)) begin
      flag <= 1'b1;
      code <= hit_code;
    end else if (clr) begin
      flag <= 1'b0;
      code <= 3'd0;
    end
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag && $stable(code)); // R9
  AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> (code != 3'd0)); // R8

endmodule

// File: rtl/dram_col_spacing_chk.sv
module dram_col_spacing_chk
  import dccs_pkg::*;
#(
  parameter int TCK_PS  = 1250,
  parameter int WL      = 6,
  parameter int BL      = 8,
  parameter int NBANK   = 8,
  parameter int CCD_NCK = 4,
  parameter int RTP_NCK = 4,
  parameter int RTP_PS  = 7500,
  parameter int WTR_NCK = 4,
  parameter int WTR_PS  = 7500,
  parameter int WR_PS   = 15000,
  parameter int MRD_NCK = 4,
  parameter int MOD_NCK = 12,
  parameter int MOD_PS  = 15000,
  localparam int BW = (NBANK < 2) ? 1 : $clog2(NBANK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_type,
  input  logic [BW-1:0] cmd_bank,
  input  logic          viol_clr,
  output logic          rdy_rd,
  output logic          rdy_wr,
  output logic          rdy_pre,
  output logic          rdy_mrs,
  output logic          rdy_oth,
  output logic          viol_flag,
  output logic [2:0]    viol_code
);
  localparam int BURST_END = WL + BL / 2;
  localparam int CCD_L = CCD_NCK;
  localparam int WTR_L = BURST_END + span_cycles(WTR_NCK, WTR_PS, TCK_PS);
  localparam int RTP_L = span_cycles(RTP_NCK, RTP_PS, TCK_PS);
  localparam int WRR_L = BURST_END + span_cycles(0, WR_PS, TCK_PS);
  localparam int MRD_L = MRD_NCK;
  localparam int MOD_L = span_cycles(MOD_NCK, MOD_PS, TCK_PS);

  logic is_rd, is_wr, is_pre, is_mrs, is_oth;
  logic acc_rd, acc_wr, acc_mrs;
  logic ccd_ok, wtr_ok, mrd_ok, mod_ok, rtp_ok, wrr_ok;
  logic sel_rdy, refused;
  logic [2:0] blk_code;

  // command class decode
  always_comb begin
    is_rd  = (cmd_type == CT_RD);
    is_wr  = (cmd_type == CT_WR);
    is_pre = (cmd_type == CT_PRE);
    is_mrs = (cmd_type == CT_MRS);
    is_oth = !(is_rd || is_wr || is_pre || is_mrs);
  end

  assign rdy_rd  = mod_ok && ccd_ok && wtr_ok;
  assign rdy_wr  = mod_ok && ccd_ok;
  assign rdy_pre = mod_ok && rtp_ok && wrr_ok;
  assign rdy_mrs = mrd_ok;
  assign rdy_oth = mod_ok;

  assign acc_rd  = cmd_valid && is_rd  && rdy_rd;
  assign acc_wr  = cmd_valid && is_wr  && rdy_wr;
  assign acc_mrs = cmd_valid && is_mrs && rdy_mrs;

  // rank-wide spacing timers
  dccs_timer #(.LIMIT(CCD_L)) u_ccd (
    .clk(clk), .rst_n(rst_n), .start(acc_rd || acc_wr), .ready(ccd_ok)
  );
  dccs_timer #(.LIMIT(WTR_L)) u_wtr (
    .clk(clk), .rst_n(rst_n), .start(acc_wr), .ready(wtr_ok)
  );
  dccs_timer #(.LIMIT(MRD_L)) u_mrd (
    .clk(clk), .rst_n(rst_n), .start(acc_mrs), .ready(mrd_ok)
  );
  dccs_timer #(.LIMIT(MOD_L)) u_mod (
    .clk(clk), .rst_n(rst_n), .start(acc_mrs), .ready(mod_ok)
  );

  // per-bank precharge timers
  dccs_bank_timers #(.NBANK(NBANK), .RTP_L(RTP_L), .WRR_L(WRR_L)) u_banks (
    .clk(clk), .rst_n(rst_n), .rd_go(acc_rd), .wr_go(acc_wr),
    .bank(cmd_bank), .rtp_ok(rtp_ok), .wrr_ok(wrr_ok)
  );

  // blocking rule for the presented command, lowest code first
  always_comb begin
    blk_code = VC_NONE;
    sel_rdy  = 1'b1;
    if (is_mrs) begin
      sel_rdy = rdy_mrs;
      if (!mrd_ok) blk_code = VC_MRD;
    end else begin
      if (is_rd)       sel_rdy = rdy_rd;
      else if (is_wr)  sel_rdy = rdy_wr;
      else if (is_pre) sel_rdy = rdy_pre;
      else             sel_rdy = rdy_oth;
      if (!mod_ok)                       blk_code = VC_MOD;
      else if ((is_rd || is_wr) && !ccd_ok) blk_code = VC_CCD;
      else if (is_rd && !wtr_ok)         blk_code = VC_WTR;
      else if (is_pre && !rtp_ok)        blk_code = VC_RTP;
      else if (is_pre && !wrr_ok)        blk_code = VC_WR;
    end
  end

  assign refused = cmd_valid && !sel_rdy;

  dccs_viol u_viol (
    .clk(clk), .rst_n(rst_n), .clr(viol_clr), .hit(refused),
    .hit_code(blk_code), .flag(viol_flag), .code(viol_code)
  );

  AST_REFUSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> viol_flag); // R8
  AST_MRD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_mrs |=> !rdy_mrs); // R5
  AST_MOD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_mrs |=> !rdy_rd && !rdy_wr && !rdy_oth); // R6
  AST_WTR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> !rdy_rd); // R2
  AST_CCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd || acc_wr) && !is_oth |=> !rdy_wr); // R1

endmodule

// File: tb/sim_dram_col_spacing_chk.sv
module sim_dram_col_spacing_chk;
  localparam int TCK = 1250;
  localparam int WL = 6;
  localparam int BL = 8;

  function automatic int cdiv(int a, int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int L_CCD = 4;
  localparam int L_WTR = WL + BL / 2 + imax(4, cdiv(7500, TCK));
  localparam int L_RTP = imax(4, cdiv(7500, TCK));
  localparam int L_WRR = WL + BL / 2 + cdiv(15000, TCK);
  localparam int L_MRD = 4;
  localparam int L_MOD = imax(12, cdiv(15000, TCK));
  localparam int MAXG  = L_WRR + 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_type = 3'd0;
  logic [2:0] cmd_bank = 3'd0;
  logic       viol_clr = 1'b0;
  logic rdy_rd, rdy_wr, rdy_pre, rdy_mrs, rdy_oth, viol_flag;
  logic [2:0] viol_code;

  int n_run = 0;
  int n_fail = 0;

  dram_col_spacing_chk u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_bank(cmd_bank), .viol_clr(viol_clr), .rdy_rd(rdy_rd), .rdy_wr(rdy_wr),
    .rdy_pre(rdy_pre), .rdy_mrs(rdy_mrs), .rdy_oth(rdy_oth),
    .viol_flag(viol_flag), .viol_code(viol_code)
  );

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic rdy_of(logic [2:0] t);
    case (t)
      3'd1: return rdy_rd;
      3'd2: return rdy_wr;
      3'd3: return rdy_pre;
      3'd4: return rdy_mrs;
      default: return rdy_oth;
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    cmd_valid = 1'b0;
    viol_clr = 1'b0;
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
  endtask

  task automatic present(logic [2:0] t, logic [2:0] b);
    cmd_valid = 1'b1;
    cmd_type = t;
    cmd_bank = b;
  endtask

  // A at one edge, B presented exactly gap cycles later.
  // Blocked by rule c1 while gap < l1, by rule c2 while gap < l2.
  task automatic sweep(string tag, logic [2:0] ta, logic [2:0] ba,
                       logic [2:0] tb, logic [2:0] bb,
                       int l1, int c1, int l2, int c2);
    for (int g = 1; g <= MAXG; g++) begin
      int ec;
      ec = (g < l1) ? c1 : ((g < l2) ? c2 : 0);
      do_reset();
      present(ta, ba);
      step();
      cmd_valid = 1'b0;
      repeat (g - 1) step();
      present(tb, bb);
      #1;
      chk({tag, " ready"}, int'(rdy_of(tb)), (ec == 0) ? 1 : 0);
      step();
      cmd_valid = 1'b0;
      chk({tag, " flag"}, int'(viol_flag), (ec != 0) ? 1 : 0);
      chk({tag, " code"}, int'(viol_code), ec);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R10 reset state
    do_reset();
    #1;
    chk("R10 rdy_rd", int'(rdy_rd), 1);
    chk("R10 rdy_wr", int'(rdy_wr), 1);
    chk("R10 rdy_pre", int'(rdy_pre), 1);
    chk("R10 rdy_mrs", int'(rdy_mrs), 1);
    chk("R10 rdy_oth", int'(rdy_oth), 1);
    chk("R10 flag", int'(viol_flag), 0);
    chk("R10 code", int'(viol_code), 0);

    // cmd_type codes: 0 oth, 1 rd, 2 wr, 3 pre, 4 mrs
    sweep("R1 rd-rd",   3'd1, 3'd0, 3'd1, 3'd5, L_CCD, 3, L_CCD, 3);
    sweep("R1 rd-wr",   3'd1, 3'd2, 3'd2, 3'd2, L_CCD, 3, L_CCD, 3);
    sweep("R1 wr-wr",   3'd2, 3'd1, 3'd2, 3'd7, L_CCD, 3, L_CCD, 3);
    sweep("R2 wr-rd",   3'd2, 3'd3, 3'd1, 3'd6, L_CCD, 3, L_WTR, 4);
    sweep("R3 rd-pre",  3'd1, 3'd4, 3'd3, 3'd4, L_RTP, 5, L_RTP, 5);
    sweep("R3 rd-pre other bank", 3'd1, 3'd4, 3'd3, 3'd5, 1, 0, 1, 0);
    sweep("R4 wr-pre",  3'd2, 3'd6, 3'd3, 3'd6, L_WRR, 6, L_WRR, 6);
    sweep("R4 wr-pre other bank", 3'd2, 3'd6, 3'd3, 3'd0, 1, 0, 1, 0);
    sweep("R5 mrs-mrs", 3'd4, 3'd0, 3'd4, 3'd0, L_MRD, 2, L_MRD, 2);
    sweep("R6 mrs-rd",  3'd4, 3'd0, 3'd1, 3'd0, L_MOD, 1, L_MOD, 1);
    sweep("R6 mrs-pre", 3'd4, 3'd0, 3'd3, 3'd3, L_MOD, 1, L_MOD, 1);
    sweep("R6 mrs-oth", 3'd4, 3'd0, 3'd0, 3'd0, L_MOD, 1, L_MOD, 1);
    sweep("R11 mrs-type7", 3'd4, 3'd0, 3'd7, 3'd0, L_MOD, 1, L_MOD, 1);
    sweep("R11 mrs-type5", 3'd4, 3'd0, 3'd5, 3'd0, L_MOD, 1, L_MOD, 1);
    sweep("R11 type6-rd", 3'd6, 3'd0, 3'd1, 3'd0, 1, 0, 1, 0);

    // R7: refused WRITE and READ start no timer
    do_reset();
    present(3'd4, 3'd0);
    step();
    present(3'd2, 3'd1);            // gap 1, refused
    step();
    present(3'd1, 3'd1);            // gap 2, refused
    step();
    cmd_valid = 1'b0;
    repeat (L_MOD - 3) step();      // now at gap L_MOD
    #1;
    chk("R7 rdy_rd after refused wr", int'(rdy_rd), 1);
    chk("R7 rdy_wr after refused rd", int'(rdy_wr), 1);
    cmd_bank = 3'd1;
    #1;
    chk("R7 rdy_pre after refused rd/wr", int'(rdy_pre), 1);
    chk("R7 flag from refused", int'(viol_flag), 1);

    // R9: first code held, clear, clear with new violation
    do_reset();
    present(3'd4, 3'd0);
    step();
    present(3'd4, 3'd0);            // MRD violation, code 2
    step();
    present(3'd1, 3'd0);            // MOD violation, must not overwrite
    step();
    cmd_valid = 1'b0;
    chk("R9 first code held", int'(viol_code), 2);
    chk("R9 flag held", int'(viol_flag), 1);
    step();
    chk("R9 flag stays", int'(viol_flag), 1);
    viol_clr = 1'b1;
    step();
    viol_clr = 1'b0;
    chk("R9 flag cleared", int'(viol_flag), 0);
    chk("R9 code cleared", int'(viol_code), 0);
    present(3'd0, 3'd0);            // still inside MRS-to-other window
    viol_clr = 1'b1;
    step();
    cmd_valid = 1'b0;
    viol_clr = 1'b0;
    chk("R9 clear with new violation flag", int'(viol_flag), 1);
    chk("R9 clear with new violation code", int'(viol_code), 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule